// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the serial-bus front end of a 2048-byte memory. The serial clock, chip select, hold and data pins are brought into the system clock domain. The block decodes the one-byte command that opens each select period. For the memory commands it gathers a two-byte address and then streams bytes in or out at bus speed. Nothing is buffered and there is never a busy state: a written byte is handed to the memory port as soon as its eighth bit arrives. A read is prefetched so that the next byte is ready before its first bit has to be driven. The address counter wraps from the top of the array to zero.

The core side has a synchronous byte-wide memory port with one cycle of read latency. A separate protection checker sits beside the block. Each write, whether to memory or to the status byte, is first raised as a request. It goes ahead on the following clock only if the checker grants it. The controller also tells the checker when the write-enable latch should be set or cleared, and it shifts out the status byte that the checker supplies. The serial clock must be at least eight times slower than the system clock.

Top module: `spi_mem_slave`

## Requirements
- R1: While reset is held and just after it is released, `spi_miso_oe`, `mem_we`, `mem_re`, `stat_we`, `prot_req`, `wel_set` and `wel_clr` are all 0.
- R2: Every byte is shifted most significant bit first and sampled on a rising serial clock edge. The command byte 06h yields a one-cycle `wel_set` pulse and 04h yields a one-cycle `wel_clr` pulse.
- R3: A transfer works the same whether the serial clock idles low (mode 0) or high (mode 3) while select is inactive.
- R4: Command 02h (write) and command 03h (read) are each followed by a 16-bit address, high byte first. Only its lowest 11 bits are kept; the 5 bits above them are ignored.
- R5: In a write, each data byte raises `prot_req` with `prot_is_status`=0, together with the byte on `wr_data` and its address on `mem_addr`. The address then steps by one per byte and wraps from 7FFh to 000h.
- R6: In a read, data bits change on falling serial clock edges. The first bit appears after the fall that follows the last address bit. Consecutive addresses are read, with the same wrap, and serial input is ignored.
- R7: Command 05h drives the `stat_rdata` byte out, and repeats it for every further byte of the select period.
- R8: Command 01h takes exactly one following byte and raises `prot_req` with `prot_is_status`=1. Later bytes in the same select period have no effect.
- R9: Only the first command of a select period is decoded. A new command is accepted only after select goes inactive and then active again.
- R10: An unrecognised command byte causes no write, no pulse and no output drive until select is released.
- R11: Raising chip select discards a partial byte and stops the output drive.
- R12: While hold is low, serial clock edges are ignored and the output is not driven. On release the transfer carries on at the same bit.
- R13: A write request commits (`mem_we` or `stat_we` for one cycle) only on the clock after `prot_gnt` is high with the request. A refused memory byte still advances the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_hold_n | input | 1 | Hold, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| mem_addr | output | 11 | Memory byte address |
| mem_re | output | 1 | Memory read strobe; data is expected on the next cycle |
| mem_we | output | 1 | Memory write strobe |
| wr_data | output | 8 | Write data for memory or status |
| mem_rdata | input | 8 | Memory read data |
| prot_req | output | 1 | Write request to the protection checker |
| prot_is_status | output | 1 | Request targets the status byte |
| prot_gnt | input | 1 | Checker permits the pending request |
| stat_we | output | 1 | Status byte write strobe |
| stat_rdata | input | 8 | Status byte to shift out |
| wel_set | output | 1 | Set write-enable latch |
| wel_clr | output | 1 | Clear write-enable latch |

## Verification
The hardest case to reach is a hold that arrives in the middle of a read byte. By then the byte has already been prefetched and some of its bits shifted out. The serial clock then toggles while hold is low. The stimulus lowers hold only after the falling edge that presents a bit has been absorbed. It toggles the clock during the hold, releases hold, and then checks that the interrupted byte and the wrapped byte after it both arrive intact. The address-wrap case is reached by writing across 7FFh with junk in the ignored upper address bits, then reading the same span back in the other clock mode.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_STRD,
    PH_STWR,
    PH_DONE
  } phase_t;

  localparam logic [7:0] OP_WEN_SET = 8'h06;
  localparam logic [7:0] OP_WEN_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_MEM_RD  = 8'h03;
  localparam logic [7:0] OP_MEM_WR  = 8'h02;

endpackage

// File: rtl/spi_sync_bits.sv
module spi_sync_bits #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_pin_front.sv
module spi_pin_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel_start,
  output logic sel_end,
  output logic sel,
  output logic held,
  output logic bit_in
);

  logic [3:0] pins_s;
  logic       sck_s, cs_s, hold_s;
  logic       sck_q, sel_q;

  // hold and select idle high, clock and data idle low
  spi_sync_bits #(
    .WIDTH   (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b1100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({hold_n, cs_n, sck, mosi}),
    .q   (pins_s)
  );

  assign hold_s = pins_s[3];
  assign cs_s   = pins_s[2];
  assign sck_s  = pins_s[1];
  assign bit_in = pins_s[0];
  assign held   = !hold_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      sck_q <= sck_s;
      if (!held) sel_q <= !cs_s;
    end
  end

  assign sel       = sel_q;
  assign sel_start = !held && !cs_s && !sel_q;
  assign sel_end   = !held && cs_s && sel_q;
  assign sck_rise  = !held && sel_q && !cs_s && sck_s && !sck_q;
  assign sck_fall  = !held && sel_q && !cs_s && !sck_s && sck_q;

endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sel_start,
  input  logic              sel_end,
  input  logic              sel,
  input  logic              held,
  input  logic              bit_in,
  output logic              miso,
  output logic              miso_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        wr_data,
  output logic              prot_req,
  output logic              prot_is_status,
  input  logic              prot_gnt,
  output logic              stat_we,
  input  logic [7:0]        stat_rdata,
  output logic              wel_set,
  output logic              wel_clr
);

  localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
  localparam int ABW        = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  phase_t           phase;
  logic [2:0]       bit_cnt;
  logic [7:0]       rx_sh, tx_sh, rbuf;
  logic [ABW-1:0]   abyte;
  logic             is_read, drive, re_d, wr_stage;
  logic [7:0]       rx_next;

  assign rx_next = {rx_sh[6:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase          <= PH_IDLE;
      bit_cnt        <= '0;
      rx_sh          <= '0;
      tx_sh          <= '0;
      rbuf           <= '0;
      abyte          <= '0;
      is_read        <= 1'b0;
      drive          <= 1'b0;
      re_d           <= 1'b0;
      wr_stage       <= 1'b0;
      miso           <= 1'b0;
      miso_oe        <= 1'b0;
      mem_addr       <= '0;
      mem_re         <= 1'b0;
      mem_we         <= 1'b0;
      wr_data        <= '0;
      prot_req       <= 1'b0;
      prot_is_status <= 1'b0;
      stat_we        <= 1'b0;
      wel_set        <= 1'b0;
      wel_clr        <= 1'b0;
    end else begin
      wel_set  <= 1'b0;
      wel_clr  <= 1'b0;
      mem_re   <= 1'b0;
      re_d     <= mem_re;
      if (re_d) rbuf <= mem_rdata;
      // commit stage: the checker answers during the request cycle
      mem_we   <= prot_req && !prot_is_status && prot_gnt;
      stat_we  <= prot_req && prot_is_status && prot_gnt;
      wr_stage <= prot_req && !prot_is_status;
      prot_req <= 1'b0;
      if (wr_stage) mem_addr <= mem_addr + 1'b1;
      miso_oe  <= drive && sel && !held;

      if (sel_end) begin
        phase   <= PH_IDLE;
        drive   <= 1'b0;
        bit_cnt <= '0;
      end else if (sel_start) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
        abyte   <= '0;
        drive   <= 1'b0;
      end else if (sck_rise && phase != PH_IDLE) begin
        bit_cnt <= bit_cnt + 1'b1;
        rx_sh   <= rx_next;
        if (bit_cnt == 3'd7) begin
          case (phase)
            PH_CMD: begin
              case (rx_next)
                OP_WEN_SET: begin wel_set <= 1'b1; phase <= PH_DONE; end
                OP_WEN_CLR: begin wel_clr <= 1'b1; phase <= PH_DONE; end
                OP_STAT_RD: phase <= PH_STRD;
                OP_STAT_WR: phase <= PH_STWR;
                OP_MEM_RD:  begin phase <= PH_ADDR; is_read <= 1'b1; end
                OP_MEM_WR:  begin phase <= PH_ADDR; is_read <= 1'b0; end
                default:    phase <= PH_DONE;
              endcase
            end
            PH_ADDR: begin
              mem_addr <= ADDR_W'({mem_addr, rx_next});
              abyte    <= abyte + 1'b1;
              if (abyte == ABW'(ADDR_BYTES - 1)) begin
                phase  <= is_read ? PH_RDATA : PH_WDATA;
                mem_re <= is_read;
              end
            end
            PH_WDATA: begin
              wr_data        <= rx_next;
              prot_req       <= 1'b1;
              prot_is_status <= 1'b0;
            end
            PH_STWR: begin
              wr_data        <= rx_next;
              prot_req       <= 1'b1;
              prot_is_status <= 1'b1;
              phase          <= PH_DONE;
            end
            default: ;
          endcase
        end
      end else if (sck_fall && (phase == PH_RDATA || phase == PH_STRD)) begin
        drive <= 1'b1;
        if (bit_cnt == 3'd0) begin
          if (phase == PH_RDATA) begin
            tx_sh    <= rbuf;
            miso     <= rbuf[7];
            mem_addr <= mem_addr + 1'b1;
            mem_re   <= 1'b1;
          end else begin
            tx_sh <= stat_rdata;
            miso  <= stat_rdata[7];
          end
        end else begin
          miso  <= tx_sh[6];
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end

  AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    $past(mem_we) |-> mem_addr == $past(mem_addr) + 1'b1); // R5

  AST_OE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    (!sel && $past(!sel)) |-> !miso_oe); // R11

  AST_OE_HELD: assert property (@(posedge clk) disable iff (rst)
    (held && $past(held)) |-> !miso_oe); // R12

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_CMD && !sel_start) |=> phase != PH_CMD); // R9

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> (phase == PH_RDATA || phase == PH_STRD || phase == PH_IDLE)); // R10

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_hold_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [7:0]        wr_data,
  input  logic [7:0]        mem_rdata,
  output logic              prot_req,
  output logic              prot_is_status,
  input  logic              prot_gnt,
  output logic              stat_we,
  input  logic [7:0]        stat_rdata,
  output logic              wel_set,
  output logic              wel_clr
);

  logic sck_rise, sck_fall, sel_start, sel_end, sel, held, bit_in;

  spi_pin_front #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_front (
    .clk       (clk),
    .rst       (rst),
    .sck       (spi_sck),
    .cs_n      (spi_cs_n),
    .hold_n    (spi_hold_n),
    .mosi      (spi_mosi),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .sel_start (sel_start),
    .sel_end   (sel_end),
    .sel       (sel),
    .held      (held),
    .bit_in    (bit_in)
  );

  spi_mem_engine #(
    .ADDR_W (ADDR_W)
  ) u_engine (
    .clk            (clk),
    .rst            (rst),
    .sck_rise       (sck_rise),
    .sck_fall       (sck_fall),
    .sel_start      (sel_start),
    .sel_end        (sel_end),
    .sel            (sel),
    .held           (held),
    .bit_in         (bit_in),
    .miso           (spi_miso),
    .miso_oe        (spi_miso_oe),
    .mem_addr       (mem_addr),
    .mem_re         (mem_re),
    .mem_we         (mem_we),
    .mem_rdata      (mem_rdata),
    .wr_data        (wr_data),
    .prot_req       (prot_req),
    .prot_is_status (prot_is_status),
    .prot_gnt       (prot_gnt),
    .stat_we        (stat_we),
    .stat_rdata     (stat_rdata),
    .wel_set        (wel_set),
    .wel_clr        (wel_clr)
  );

  AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && stat_we)); // R13

endmodule

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, mosi = 1'b0;
  logic        miso, miso_oe, mem_re, mem_we, prot_req, prot_is_status;
  logic        stat_we, wel_set, wel_clr;
  logic        prot_gnt = 1'b1;
  logic [10:0] mem_addr;
  logic [7:0]  wr_data, mem_rdata = '0;
  logic [7:0]  stat_rdata = 8'h8C;

  spi_mem_slave u_dut (
    .clk (clk), .rst (rst), .spi_sck (sck), .spi_cs_n (cs_n),
    .spi_hold_n (hold_n), .spi_mosi (mosi), .spi_miso (miso),
    .spi_miso_oe (miso_oe), .mem_addr (mem_addr), .mem_re (mem_re),
    .mem_we (mem_we), .wr_data (wr_data), .mem_rdata (mem_rdata),
    .prot_req (prot_req), .prot_is_status (prot_is_status),
    .prot_gnt (prot_gnt), .stat_we (stat_we), .stat_rdata (stat_rdata),
    .wel_set (wel_set), .wel_clr (wel_clr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural memory on the core side
  logic [7:0] mem [2048];
  initial for (int a = 0; a < 2048; a++) mem[a] = 8'(a) ^ 8'h3C;
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= wr_data;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  int   n_chk = 0, n_err = 0, n_set = 0, n_clr = 0;
  logic oe_seen = 1'b0, mode3 = 1'b0, finished = 1'b0;
  logic [19:0] exp_q [$];   // {is_status, addr, data}

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // reference compare on every clock: commits must match the expected queue
  always @(negedge clk) begin
    if (!rst) begin
      if (miso_oe) oe_seen = 1'b1;
      if (wel_set) n_set++;
      if (wel_clr) n_clr++;
      if (mem_we || stat_we) begin
        if (exp_q.size() == 0) begin
          chk("R13 unexpected commit", {stat_we, mem_addr, wr_data}, 32'hFFFFFFFF);
        end else begin
          logic [19:0] e;
          e = exp_q.pop_front();
          if (e[19]) chk("R8 status commit", {stat_we, 11'd0, wr_data}, {e[19], 11'd0, e[7:0]});
          else       chk("R5 memory commit", {stat_we, mem_addr, wr_data}, e);
        end
      end
    end
  end

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_at, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0; mosi = tx[7-i]; half();
      if (i == hold_at) begin
        hold_n = 1'b0; half();
        chk("R12 output released in hold", miso_oe, 0);
        sck = 1'b1; half(); sck = 1'b0; half();
        hold_n = 1'b1; half();
      end
      sck = 1'b1; rx[7-i] = miso; half();
    end
  endtask

  task automatic start(input logic m3);
    mode3 = m3; sck = m3; half(); cs_n = 1'b0; half();
  endtask

  task automatic stop();
    if (!mode3) begin sck = 1'b0; half(); end
    cs_n = 1'b1; half(); half();
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r;
    xfer(b, 8, -1, r);
  endtask

  task automatic recv(input logic [7:0] exp, input int hold_at, input string what);
    logic [7:0] r;
    xfer(8'hFF, 8, hold_at, r);
    chk(what, r, exp);
    chk({what, " drive"}, miso_oe, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 reset outputs", {miso_oe, mem_we, mem_re, stat_we, prot_req, wel_set, wel_clr}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {miso_oe, mem_we, mem_re, stat_we, prot_req, wel_set, wel_clr}, 0);

    // R2 latch commands, mode 0 then mode 3 (R3)
    start(0); send(8'h06); stop();
    chk("R2 set pulse", n_set, 1);
    start(1); send(8'h04); stop();
    chk("R2 R3 clear pulse mode 3", n_clr, 1);

    // R4 R5 write across the top with junk upper address bits
    exp_q.push_back({1'b0, 11'h7FE, 8'hA1});
    exp_q.push_back({1'b0, 11'h7FF, 8'hB2});
    exp_q.push_back({1'b0, 11'h000, 8'hC3});
    oe_seen = 1'b0;
    start(0); send(8'h02); send(8'hFF); send(8'hFE);
    send(8'hA1); send(8'hB2); send(8'hC3); stop();
    chk("R5 all writes committed", exp_q.size(), 0);
    chk("R11 no drive in write", oe_seen, 0);

    // R6 R3 R4 read back in mode 3, SI held high
    start(1); send(8'h03); send(8'hA7); send(8'hFE);
    recv(8'hA1, -1, "R6 byte 7FE");
    recv(8'hB2, -1, "R6 byte 7FF");
    recv(8'hC3, -1, "R6 wrap to 000");
    stop();
    chk("R11 drive off after deselect", miso_oe, 0);

    // R13 refused write
    prot_gnt = 1'b0;
    start(0); send(8'h02); send(8'h00); send(8'h10); send(8'h5A); stop();
    prot_gnt = 1'b1;
    start(0); send(8'h03); send(8'h00); send(8'h10);
    recv(8'h2C, -1, "R13 refused byte kept");
    stop();

    // R7 status read repeats
    start(1); send(8'h05);
    recv(8'h8C, -1, "R7 status");
    recv(8'h8C, -1, "R7 status repeat");
    stop();

    // R8 status write takes one byte only; refused one commits nothing
    exp_q.push_back({1'b1, 11'h000, 8'h0C});
    start(0); send(8'h01); send(8'h0C); send(8'h33); stop();
    chk("R8 single status commit", exp_q.size(), 0);
    prot_gnt = 1'b0;
    start(0); send(8'h01); send(8'h44); stop();
    prot_gnt = 1'b1;

    // R9 second command in one select period
    start(0); send(8'h06); send(8'h04); send(8'h02); stop();
    chk("R9 first command decoded", n_set, 2);
    chk("R9 second command ignored", n_clr, 1);

    // R10 unknown command
    oe_seen = 1'b0;
    start(1); send(8'hAB); send(8'h02); send(8'h00); send(8'h10); send(8'h77); stop();
    chk("R10 no drive", oe_seen, 0);
    chk("R10 no pulses", {n_set, n_clr}, {32'd2, 32'd1});

    // R11 partial command discarded, next select decodes cleanly
    begin
      logic [7:0] r;
      start(0); xfer(8'h06, 4, -1, r); stop();
    end
    chk("R11 partial dropped", n_set, 2);
    start(0); send(8'h04); stop();
    chk("R11 fresh command", n_clr, 2);

    // R12 hold inside a read byte, then wrap
    start(0); send(8'h03); send(8'h07); send(8'hFF);
    recv(8'hB2, 3, "R12 byte across hold");
    recv(8'hC3, -1, "R6 wrap after hold");
    stop();

    repeat (20) @(negedge clk);
    chk("R13 no stray commits", exp_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule